// File: doc/BRIEF.md
# Serial Port FIFO Control Register

This block holds the FIFO control register of a 16550-style serial port and turns each write to it into the side effects that the rest of the port carries out. A write presents an 8-bit value with a one-cycle strobe. The block keeps only the bits that are meant to persist. It decodes the receive trigger threshold and reports whether the FIFOs are enabled, so the interrupt identification register can show it. It also issues one-cycle control pulses that flush the receive and transmit FIFOs, adjust the line status, stop the character timeout and request an interrupt re-evaluation.

The FIFOs, the timeout counter and the interrupt logic sit outside this block. They see it only through the registered pulses and levels below. All outputs change on the clock edge that samples the write strobe.

Top module: `fifo_ctl_reg`

## Requirements
- R1: After reset the stored value is 0x00, `fifo_on` is 00, `rx_level` is 1 and every pulse output is low.
- R2: A write stores `wr_data & 0xC9` (bit 0 enable, bit 3 mode, bits 7:6 threshold select). The flush bits 1 and 2 never persist.
- R3: A write whose bit 0 differs from the stored bit 0 pulses both `rx_flush` and `tx_flush`, whatever bits 1 and 2 hold.
- R4: A receive flush (bit 1 set, or forced by R3) pulses `rx_flush`, `rx_stat_clr` (clear data-ready and break-indicator) and `tmo_cancel` (stop the timeout and drop its pending flag) together.
- R5: A transmit flush (bit 2 set, or forced by R3) pulses `tx_flush`, `thre_set` and `thre_pend_set` together.
- R6: `fifo_on` is 11 while the stored bit 0 is 1, and 00 otherwise.
- R7: A write with bit 0 set loads `rx_level` from bits 7:6: 00 gives 1, 01 gives 4, 10 gives 8 and 11 gives 14 (with a 16-entry FIFO).
- R8: A write with bit 0 clear leaves `rx_level` unchanged.
- R9: Each write pulses `irq_eval` for exactly one cycle. A cycle with no write produces no pulse on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Written value |
| ctrl_q | output | 8 | Retained register value |
| fifo_on | output | 2 | FIFO-enabled bits for interrupt identification |
| rx_level | output | LVL_W | Receive trigger threshold in bytes |
| rx_flush | output | 1 | Empty receive FIFO pulse |
| rx_stat_clr | output | 1 | Clear data-ready and break-indicator pulse |
| tmo_cancel | output | 1 | Stop character timeout and clear its pending flag |
| tx_flush | output | 1 | Empty transmit FIFO pulse |
| thre_set | output | 1 | Set holding-register-empty status pulse |
| thre_pend_set | output | 1 | Raise holding-register-empty pending request |
| irq_eval | output | 1 | Re-evaluate interrupt output pulse |

## Verification
Random byte writes exercise every combination of enable, flush and threshold bits against a stored state that keeps changing. This separates flushes requested explicitly from flushes forced by an enable toggle. Directed writes repeat the same enable value with no flush bits, to show that nothing is forced. Other directed writes disable the FIFOs with a new threshold selection, to show that the threshold holds. Idle cycles between writes show that each pulse lasts only one cycle.

// File: rtl/fifo_ctl_pkg.sv
package fifo_ctl_pkg;
  localparam int BIT_EN    = 0;
  localparam int BIT_RXRST = 1;
  localparam int BIT_TXRST = 2;
  localparam logic [7:0] KEEP_MASK = 8'hC9;

  typedef struct packed {
    logic rx_flush;
    logic rx_stat_clr;
    logic tmo_cancel;
    logic tx_flush;
    logic thre_set;
    logic thre_pend_set;
    logic irq_eval;
  } fifo_ctl_pulse_t;

  localparam int PULSE_W = $bits(fifo_ctl_pulse_t);
endpackage

// File: rtl/fifo_ctl_decode.sv
module fifo_ctl_decode
  import fifo_ctl_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic            wr_en,
  input  logic [7:0]      wr_data,
  input  logic [7:0]      ctrl_q,
  input  logic [LVL_W-1:0] level_q,
  output fifo_ctl_pulse_t pulse_d,
  output logic [7:0]      ctrl_d,
  output logic [LVL_W-1:0] level_d
);
  localparam logic [LVL_W-1:0] LVL_SEL0 = LVL_W'(1);
  localparam logic [LVL_W-1:0] LVL_SEL1 = LVL_W'(DEPTH / 4);
  localparam logic [LVL_W-1:0] LVL_SEL2 = LVL_W'(DEPTH / 2);
  localparam logic [LVL_W-1:0] LVL_SEL3 = LVL_W'(DEPTH - 2);

  logic en_toggle;
  logic do_rx;
  logic do_tx;
  logic [LVL_W-1:0] sel_level;

  always_comb begin
    en_toggle = wr_data[BIT_EN] ^ ctrl_q[BIT_EN];
    do_rx     = wr_en & (wr_data[BIT_RXRST] | en_toggle);
    do_tx     = wr_en & (wr_data[BIT_TXRST] | en_toggle);
  end

  always_comb begin
    unique case (wr_data[7:6])
      2'b00:   sel_level = LVL_SEL0;
      2'b01:   sel_level = LVL_SEL1;
      2'b10:   sel_level = LVL_SEL2;
      default: sel_level = LVL_SEL3;
    endcase
  end

  always_comb begin
    ctrl_d  = ctrl_q;
    level_d = level_q;
    if (wr_en) begin
      ctrl_d = wr_data & KEEP_MASK;
      if (wr_data[BIT_EN]) level_d = sel_level;
    end
  end

  always_comb begin
    pulse_d.rx_flush      = do_rx;
    pulse_d.rx_stat_clr   = do_rx;
    pulse_d.tmo_cancel    = do_rx;
    pulse_d.tx_flush      = do_tx;
    pulse_d.thre_set      = do_tx;
    pulse_d.thre_pend_set = do_tx;
    pulse_d.irq_eval      = wr_en;
  end
endmodule

// File: rtl/fifo_ctl_pulse_reg.sv
module fifo_ctl_pulse_reg #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q[i] <= 1'b0;
      else        q[i] <= d[i];
    end
  end
endmodule

// File: rtl/fifo_ctl_reg.sv
module fifo_ctl_reg
  import fifo_ctl_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [7:0]       wr_data,
  output logic [7:0]       ctrl_q,
  output logic [1:0]       fifo_on,
  output logic [LVL_W-1:0] rx_level,
  output logic             rx_flush,
  output logic             rx_stat_clr,
  output logic             tmo_cancel,
  output logic             tx_flush,
  output logic             thre_set,
  output logic             thre_pend_set,
  output logic             irq_eval
);
  fifo_ctl_pulse_t pulse_d;
  fifo_ctl_pulse_t pulse_q;
  logic [7:0]       ctrl_d;
  logic [LVL_W-1:0] level_d;

  fifo_ctl_decode #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_dec (
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .ctrl_q  (ctrl_q),
    .level_q (rx_level),
    .pulse_d (pulse_d),
    .ctrl_d  (ctrl_d),
    .level_d (level_d)
  );

  fifo_ctl_pulse_reg #(.W(PULSE_W)) u_pulse (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pulse_d),
    .q     (pulse_q)
  );

  // State registers, loaded only on a write.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      rx_level <= LVL_W'(1);
    end else if (wr_en) begin
      ctrl_q   <= ctrl_d;
      rx_level <= level_d;
    end
  end

  always_comb begin
    fifo_on       = {2{ctrl_q[BIT_EN]}};
    rx_flush      = pulse_q.rx_flush;
    rx_stat_clr   = pulse_q.rx_stat_clr;
    tmo_cancel    = pulse_q.tmo_cancel;
    tx_flush      = pulse_q.tx_flush;
    thre_set      = pulse_q.thre_set;
    thre_pend_set = pulse_q.thre_pend_set;
    irq_eval      = pulse_q.irq_eval;
  end
endmodule

// File: rtl/fifo_ctl_reg_chk.sv
module fifo_ctl_reg_chk #(
  parameter int LVL_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [7:0]       wr_data,
  input logic [7:0]       ctrl_q,
  input logic [LVL_W-1:0] rx_level,
  input logic             rx_flush,
  input logic             rx_stat_clr,
  input logic             tmo_cancel,
  input logic             tx_flush,
  input logic             thre_set,
  input logic             thre_pend_set,
  input logic             irq_eval
);
  p_store_mask_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ctrl_q == ($past(wr_data) & 8'hC9));

  p_toggle_flush_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_data[0] != ctrl_q[0])) |=> (rx_flush && tx_flush));

  p_rx_side_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_flush |-> (rx_stat_clr && tmo_cancel && irq_eval));

  p_tx_side_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_flush |-> (thre_set && thre_pend_set && irq_eval));

  p_level_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_data[0]) |=> $stable(rx_level));

  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> !(irq_eval || rx_flush || tx_flush));

  p_write_eval_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> irq_eval);
endmodule

bind fifo_ctl_reg fifo_ctl_reg_chk #(.LVL_W(LVL_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .wr_en         (wr_en),
  .wr_data       (wr_data),
  .ctrl_q        (ctrl_q),
  .rx_level      (rx_level),
  .rx_flush      (rx_flush),
  .rx_stat_clr   (rx_stat_clr),
  .tmo_cancel    (tmo_cancel),
  .tx_flush      (tx_flush),
  .thre_set      (thre_set),
  .thre_pend_set (thre_pend_set),
  .irq_eval      (irq_eval)
);

// File: tb/fifo_ctl_reg_test.sv
module fifo_ctl_reg_test;
  localparam int CLK_PERIOD = 10;
  localparam int LVL_W = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] ctrl_q;
  logic [1:0] fifo_on;
  logic [LVL_W-1:0] rx_level;
  logic rx_flush, rx_stat_clr, tmo_cancel, tx_flush, thre_set, thre_pend_set, irq_eval;

  int n_chk = 0;
  int n_err = 0;
  logic [7:0] m_ctrl;
  logic [LVL_W-1:0] m_lvl;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fifo_ctl_reg uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .ctrl_q(ctrl_q), .fifo_on(fifo_on), .rx_level(rx_level),
    .rx_flush(rx_flush), .rx_stat_clr(rx_stat_clr), .tmo_cancel(tmo_cancel),
    .tx_flush(tx_flush), .thre_set(thre_set), .thre_pend_set(thre_pend_set),
    .irq_eval(irq_eval)
  );

  function automatic logic [LVL_W-1:0] ref_level(input logic [1:0] s);
    case (s)
      2'd0: return 5'd1;
      2'd1: return 5'd4;
      2'd2: return 5'd8;
      default: return 5'd14;
    endcase
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_idle();
    chk("R9 idle pulses", {rx_flush, rx_stat_clr, tmo_cancel, tx_flush,
        thre_set, thre_pend_set, irq_eval}, 0);
  endtask

  task automatic do_write(input logic [7:0] v);
    logic tg, erx, etx;
    @(negedge clk);
    chk_idle();
    tg  = v[0] ^ m_ctrl[0];
    erx = v[1] | tg;
    etx = v[2] | tg;
    m_ctrl = v & 8'hC9;
    if (v[0]) m_lvl = ref_level(v[7:6]);
    wr_en = 1'b1; wr_data = v;
    @(negedge clk);
    wr_en = 1'b0;
    chk("R2 stored value", ctrl_q, m_ctrl);
    chk("R3 R4 rx flush", rx_flush, erx);
    chk("R4 rx status clear", {rx_stat_clr, tmo_cancel}, {erx, erx});
    chk("R3 R5 tx flush", tx_flush, etx);
    chk("R5 thre strobes", {thre_set, thre_pend_set}, {etx, etx});
    chk("R6 fifo_on", fifo_on, {m_ctrl[0], m_ctrl[0]});
    chk("R7 R8 rx_level", rx_level, m_lvl);
    chk("R9 irq_eval", irq_eval, 1);
  endtask

  initial begin
    void'($urandom(32'd1234));
    m_ctrl = 8'h00; m_lvl = 5'd1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 ctrl_q", ctrl_q, 0);
    chk("R1 fifo_on", fifo_on, 0);
    chk("R1 rx_level", rx_level, 1);
    chk_idle();
    // Directed corners
    do_write(8'h00);          // no toggle, nothing forced (R3)
    do_write(8'hC1);          // enable: forced flush, level 14 (R7)
    do_write(8'hC1);          // same enable, no flush
    do_write(8'h43);          // rx flush only, level 4 (R4 R7)
    do_write(8'h05);          // tx flush only, level 1 (R5)
    do_write(8'h8F);          // both flushes, keep 0x89 (R2)
    do_write(8'h40);          // disable: forced flush, level held (R8)
    do_write(8'hC6);          // disabled, flush bits only, level held (R8)
    do_write(8'h81);          // enable, level 8
    // Random
    for (int i = 0; i < 400; i++) begin
      do_write(8'($urandom()));
      if ($urandom_range(3) == 0) begin
        @(negedge clk);
        chk_idle();
      end
    end
    @(negedge clk);
    chk_idle();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog actual=running expected=finished");
      end
    join_any
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule